// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block provides a byte-wide configuration register space for a host that has only two I/O addresses. One address is an index port and the other is a data port. The space stays locked after reset. While it is locked, the index port does nothing except watch for a fixed four-byte key. Once the key has arrived, the host writes a register number to the index port and then reads or writes that register through the data port. The host can lock the space again at any time with an exit write.

A logical-device-number register chooses which bank of per-device registers appears at index 0x30 and above. Each bank holds an enable bit and a 16-bit base address. These values are driven out to the device functions, which live outside this block. The block also holds a read-only 16-bit chip identifier and a 4-bit revision.

The host bus model has an address, a write byte, and one-cycle read and write strobes. Read data is registered.

Top module: `cfgp_port`

## Requirements
- R1: After reset the space is locked, all device enables and base addresses are zero, and `host_rdata` is 0xFF. While locked, a read of either port loads 0xFF into `host_rdata`, and data-port writes change no register.
- R2: The space unlocks after the index port (address 0x2E) receives the bytes 0x87, 0x01, 0x55, 0x55 in that order. The write that completes the key does not change the current index, which stays 0x00.
- R3: While locked, an index-port write that does not match the next expected key byte restarts matching. If that mismatching byte is 0x87, it counts as the first key byte.
- R4: While unlocked, writing 0x02 to the data port (address 0x2F) while the index is 0x02 locks the space and clears the index to 0x00. Any other data byte written at index 0x02 is dropped, and the space stays unlocked.
- R5: Index 0x20 reads the chip identifier's high byte and index 0x21 its low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 zero. Writes to all three are dropped.
- R6: Index 0x07 is a read/write logical-device-number register (reset 0x00). Device n (0 ≤ n < NUM_LDEV) is the bank visible at index 0x30 and above when this register holds n.
- R7: Index 0x30 of the selected device is its enable. Only bit 0 is stored, bits 7:1 read as zero, and bit 0 drives `dev_active[n]`.
- R8: Index 0x60 of the selected device holds base-address bits 15:8 and index 0x61 holds bits 7:0. Device n's base address drives `dev_base[16n+15:16n]`.
- R9: Reads of undefined indices return 0x00 and writes to them are dropped. When the logical device number is NUM_LDEV or more, the banked indices read 0x00 and writes to them are dropped.
- R10: A read strobe on a port loads `host_rdata` at that clock edge, and the value holds until the next port read. While unlocked, an index-port read returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_rdata | output | 8 | Registered read byte |
| dev_active | output | NUM_LDEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_LDEV | Base address of each logical device, device 0 in the low bits |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. One property checks this assumption directly. The bench issues exactly one strobe per access, each lasting a single cycle, with at least one idle cycle between accesses.

The properties also assume that the address is stable while a strobe is high. The bench drives the address and the strobe together on the falling edge and holds both until the next falling edge.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam logic [7:0] KEY_B0      = 8'h87;
    localparam logic [7:0] KEY_B1      = 8'h01;
    localparam logic [7:0] KEY_B2      = 8'h55;
    localparam logic [7:0] KEY_B3      = 8'h55;

    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] EXIT_CODE   = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;

    localparam logic [7:0] LOCKED_READ = 8'hFF;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_GOT1,
        KS_GOT2,
        KS_GOT3,
        KS_OPEN
    } key_state_e;

endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    input  logic [7:0] cur_index,
    output logic       unlocked
);

    typedef struct packed {
        key_state_e st;
    } lock_s;

    lock_s st_d, st_q;
    logic [7:0] want_byte;
    key_state_e next_on_match;

    always_comb begin
        want_byte     = KEY_B0;
        next_on_match = KS_GOT1;
        case (st_q.st)
            KS_IDLE: begin want_byte = KEY_B0; next_on_match = KS_GOT1; end
            KS_GOT1: begin want_byte = KEY_B1; next_on_match = KS_GOT2; end
            KS_GOT2: begin want_byte = KEY_B2; next_on_match = KS_GOT3; end
            KS_GOT3: begin want_byte = KEY_B3; next_on_match = KS_OPEN; end
            default: begin want_byte = KEY_B0; next_on_match = KS_OPEN; end
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (st_q.st == KS_OPEN) begin
            if (dat_wr && cur_index == IDX_EXIT && wdata == EXIT_CODE)
                st_d.st = KS_IDLE;
        end else if (idx_wr) begin
            if (wdata == want_byte)
                st_d.st = next_on_match;
            else if (wdata == KEY_B0)
                st_d.st = KS_GOT1;
            else
                st_d.st = KS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{st: KS_IDLE};
        else        st_q <= st_d;
    end

    assign unlocked = (st_q.st == KS_OPEN);

endmodule

// File: rtl/cfgp_ldev_bank.sv
module cfgp_ldev_bank
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        wr,
    input  logic [7:0]  index,
    input  logic [7:0]  wdata,
    output logic        active,
    output logic [15:0] base,
    output logic [7:0]  rd_byte
);

    typedef struct packed {
        logic        act;
        logic [15:0] base;
    } bank_s;

    bank_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel && wr) begin
            case (index)
                IDX_ACT:     st_d.act        = wdata[0];
                IDX_BASE_HI: st_d.base[15:8] = wdata;
                IDX_BASE_LO: st_d.base[7:0]  = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        if (sel) begin
            case (index)
                IDX_ACT:     rd_byte = {7'b0, st_q.act};
                IDX_BASE_HI: rd_byte = st_q.base[15:8];
                IDX_BASE_LO: rd_byte = st_q.base[7:0];
                default:     rd_byte = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;
    assign base   = st_q.base;

endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] DATA_ADDR  = 16'h002F,
    parameter int          NUM_LDEV   = 4,
    parameter logic [15:0] CHIP_ID    = 16'h8728,
    parameter logic [3:0]  CHIP_REV   = 4'h6
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic [7:0]             host_wdata,
    input  logic                   host_rd,
    input  logic                   host_wr,
    output logic [7:0]             host_rdata,
    output logic [NUM_LDEV-1:0]    dev_active,
    output logic [16*NUM_LDEV-1:0] dev_base
);

    localparam int BASE_W = 16;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] ldn;
        logic [7:0] rdata;
    } port_s;

    port_s st_d, st_q;

    logic       unlocked;
    logic       hit_idx, hit_dat;
    logic       idx_wr, dat_wr, idx_rd, dat_rd;
    logic [7:0] cur_index;
    logic [7:0] reg_rd;
    logic [7:0] bank_or;
    logic [7:0] bank_rd [NUM_LDEV];

    assign hit_idx   = (host_addr == INDEX_ADDR[ADDR_W-1:0]);
    assign hit_dat   = (host_addr == DATA_ADDR[ADDR_W-1:0]);
    assign idx_wr    = host_wr && hit_idx;
    assign dat_wr    = host_wr && hit_dat;
    assign idx_rd    = host_rd && hit_idx;
    assign dat_rd    = host_rd && hit_dat;
    assign cur_index = st_q.index;

    cfgp_unlock unlock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .wdata     (host_wdata),
        .cur_index (st_q.index),
        .unlocked  (unlocked)
    );

    for (genvar i = 0; i < NUM_LDEV; i++) begin : g_bank
        logic sel;
        assign sel = (st_q.ldn == 8'(i));
        cfgp_ldev_bank bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel),
            .wr      (unlocked && dat_wr),
            .index   (st_q.index),
            .wdata   (host_wdata),
            .active  (dev_active[i]),
            .base    (dev_base[BASE_W*i +: BASE_W]),
            .rd_byte (bank_rd[i])
        );
    end

    always_comb begin
        bank_or = 8'h00;
        for (int i = 0; i < NUM_LDEV; i++) bank_or = bank_or | bank_rd[i];
    end

    always_comb begin
        case (st_q.index)
            IDX_LDN:   reg_rd = st_q.ldn;
            IDX_ID_HI: reg_rd = CHIP_ID[15:8];
            IDX_ID_LO: reg_rd = CHIP_ID[7:0];
            IDX_REV:   reg_rd = {4'h0, CHIP_REV};
            default:   reg_rd = bank_or;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (unlocked) begin
            if (idx_wr) st_d.index = host_wdata;
            if (dat_wr && st_q.index == IDX_LDN) st_d.ldn = host_wdata;
            if (dat_wr && st_q.index == IDX_EXIT && host_wdata == EXIT_CODE)
                st_d.index = 8'h00;
            if (idx_rd) st_d.rdata = st_q.index;
            if (dat_rd) st_d.rdata = reg_rd;
        end else if (idx_rd || dat_rd) begin
            st_d.rdata = LOCKED_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{index: 8'h00, ldn: 8'h00, rdata: LOCKED_READ};
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;

endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] DATA_ADDR  = 16'h002F,
    parameter int          NUM_LDEV   = 4,
    parameter logic [15:0] CHIP_ID    = 16'h8728
)(
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      host_addr,
    input logic [7:0]             host_wdata,
    input logic                   host_rd,
    input logic                   host_wr,
    input logic [7:0]             host_rdata,
    input logic [NUM_LDEV-1:0]    dev_active,
    input logic [16*NUM_LDEV-1:0] dev_base,
    input logic                   unlocked,
    input logic [7:0]             cur_index
);

    logic on_dat, on_idx;
    assign on_dat = (host_addr == DATA_ADDR[ADDR_W-1:0]);
    assign on_idx = (host_addr == INDEX_ADDR[ADDR_W-1:0]);

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_wr));

    assert_locked_read_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && host_rd && (on_dat || on_idx)) |=> host_rdata == LOCKED_READ);

    assert_locked_no_effect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(dev_active) && $stable(dev_base)));

    assert_unlock_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(host_wr && on_idx && host_wdata == KEY_B3));

    assert_exit_relocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && host_wr && on_dat && cur_index == IDX_EXIT && host_wdata == EXIT_CODE)
        |=> (!unlocked && cur_index == 8'h00));

    assert_chip_id_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && host_rd && on_dat && cur_index == IDX_ID_HI)
        |=> host_rdata == CHIP_ID[15:8]);

    assert_undefined_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && host_rd && on_dat && cur_index == 8'h10) |=> host_rdata == 8'h00);

endmodule

bind cfgp_port cfgp_port_chk #(
    .ADDR_W     (ADDR_W),
    .INDEX_ADDR (INDEX_ADDR),
    .DATA_ADDR  (DATA_ADDR),
    .NUM_LDEV   (NUM_LDEV),
    .CHIP_ID    (CHIP_ID)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_rdata (host_rdata),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .unlocked   (unlocked),
    .cur_index  (cur_index)
);

// File: tb/cfgp_port_tb_top.sv
`timescale 1ns/1ps
module cfgp_port_tb_top;

    localparam int          NL   = 4;
    localparam logic [15:0] IDXA = 16'h002E;
    localparam logic [15:0] DATA = 16'h002F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [7:0]    host_rdata;
    logic [NL-1:0] dev_active;
    logic [16*NL-1:0] dev_base;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cfgp_port #(.NUM_LDEV(NL), .CHIP_ID(16'h8728), .CHIP_REV(4'h6)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .dev_active(dev_active), .dev_base(dev_base)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_port(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
        wr_port(IDXA, idx);
        wr_port(DATA, v);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
        wr_port(IDXA, idx);
        rd_port(DATA, v);
    endtask

    task automatic send_key();
        wr_port(IDXA, 8'h87); wr_port(IDXA, 8'h01);
        wr_port(IDXA, 8'h55); wr_port(IDXA, 8'h55);
    endtask

    task automatic relock();
        reg_wr(8'h02, 8'h02);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 reset rdata", host_rdata, 8'hFF);
        check("R1 reset active", dev_active, 0);
        check("R1 reset base", dev_base, 0);
        rd_port(DATA, v);
        check("R1 locked data read", v, 8'hFF);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        reg_wr(8'h30, 8'h01);
        check("R1 locked write ignored", dev_active, 0);
        rd_port(IDXA, v);
        check("R1 locked index read", v, 8'hFF);
    endtask

    task automatic t_unlock();
        logic [7:0] v;
        send_key();
        rd_port(IDXA, v);
        check("R2 index after unlock", v, 8'h00);
        reg_rd(8'h20, v);
        check("R2 unlocked id read", v, 8'h87);
        rd_port(IDXA, v);
        check("R10 index port read", v, 8'h20);
    endtask

    task automatic t_chip();
        logic [7:0] v;
        reg_rd(8'h21, v);
        check("R5 id low", v, 8'h28);
        reg_rd(8'h22, v);
        check("R5 revision", v, 8'h06);
        reg_wr(8'h20, 8'h11);
        rd_port(DATA, v);
        check("R5 id write dropped", v, 8'h87);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        reg_wr(8'h07, 8'h00);
        reg_wr(8'h30, 8'h01);
        check("R7 dev0 active", dev_active, 4'b0001);
        reg_wr(8'h07, 8'h02);
        reg_wr(8'h30, 8'hFF);
        check("R7 dev2 active", dev_active, 4'b0101);
        rd_port(DATA, v);
        check("R7 act upper bits zero", v, 8'h01);
        reg_rd(8'h07, v);
        check("R6 ldn readback", v, 8'h02);
        reg_wr(8'h07, 8'h01);
        reg_wr(8'h60, 8'h12);
        reg_wr(8'h61, 8'h34);
        check("R8 dev1 base", dev_base, 64'h0000_0000_1234_0000);
        reg_rd(8'h60, v);
        check("R8 base high read", v, 8'h12);
        reg_wr(8'h07, 8'h00);
        reg_rd(8'h61, v);
        check("R6 dev0 base separate", v, 8'h00);
        reg_rd(8'h30, v);
        check("R6 dev0 act read", v, 8'h01);
        reg_wr(8'h30, 8'h00);
        check("R7 dev0 cleared", dev_active, 4'b0100);
    endtask

    task automatic t_undef();
        logic [7:0] v;
        reg_wr(8'h07, 8'h07);
        reg_wr(8'h30, 8'h01);
        check("R9 out-of-range ldn write", dev_active, 4'b0100);
        rd_port(DATA, v);
        check("R9 out-of-range ldn read", v, 8'h00);
        reg_wr(8'h10, 8'h5A);
        rd_port(DATA, v);
        check("R9 undefined index read", v, 8'h00);
        check("R9 undefined write no effect", dev_base, 64'h0000_0000_1234_0000);
        reg_wr(8'h07, 8'h00);
    endtask

    task automatic t_relock();
        logic [7:0] v;
        reg_wr(8'h02, 8'h03);
        reg_rd(8'h20, v);
        check("R4 wrong exit code stays open", v, 8'h87);
        relock();
        rd_port(DATA, v);
        check("R4 relocked data read", v, 8'hFF);
        reg_wr(8'h30, 8'h01);
        check("R4 relocked write ignored", dev_active, 4'b0100);
        send_key();
        rd_port(IDXA, v);
        check("R4 index cleared by exit", v, 8'h00);
        relock();
    endtask

    task automatic t_key_restart();
        logic [7:0] v;
        wr_port(IDXA, 8'h87); wr_port(IDXA, 8'h01);
        wr_port(IDXA, 8'h87); wr_port(IDXA, 8'h01);
        wr_port(IDXA, 8'h55); wr_port(IDXA, 8'h55);
        rd_port(IDXA, v);
        check("R3 87 restarts key", v, 8'h00);
        relock();
        wr_port(IDXA, 8'h87); wr_port(IDXA, 8'h01);
        wr_port(IDXA, 8'h55); wr_port(IDXA, 8'h00);
        wr_port(IDXA, 8'h55);
        rd_port(IDXA, v);
        check("R3 wrong byte resets", v, 8'hFF);
        wr_port(IDXA, 8'h87); wr_port(IDXA, 8'h87);
        wr_port(IDXA, 8'h01); wr_port(IDXA, 8'h55);
        wr_port(IDXA, 8'h55);
        rd_port(IDXA, v);
        check("R3 double 87", v, 8'h00);
        relock();
        wr_port(IDXA, 8'h87); wr_port(IDXA, 8'h01);
        wr_port(IDXA, 8'h55); wr_port(IDXA, 8'h87);
        wr_port(IDXA, 8'h01); wr_port(IDXA, 8'h55);
        wr_port(IDXA, 8'h55);
        rd_port(IDXA, v);
        check("R3 87 at third byte", v, 8'h00);
        relock();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_unlock();
        t_chip();
        t_banks();
        t_undef();
        t_relock();
        t_key_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule